// File: doc/BRIEF.md
# SPI Master Transmitter with Chip-Select Hold Control

This block is the transmit side of an SPI master. A write port places one 8-bit character and its target chip-select number into a single-entry holding register. The holding register drains into a shift register, which sends the character MSB first in SPI mode 0. SCLK runs from a programmable divider of the system clock.

When a character ends, the controller chooses one of three outcomes for the active chip-select. It can keep the line asserted, drop the line and wait a programmable gap before the next assertion, or release the line. The choice depends on a per-line keep-active bit, a per-line force-inactive bit, a one-shot last-transfer flag, and whether the next character was already waiting for the same line. A holding-register-empty flag tells the writer that a new character can be written.

Top module: `spi_cs_hold_master`

## Requirements
- R1: Characters are 8 bits, MSB first, in SPI mode 0. SCLK idles low, each bit is sampled on the SCLK rising edge, and MOSI changes on the falling edge. Each SCLK half-period lasts `clk_div` system cycles, and a value of 0 is treated as 1.
- R2: `hold_empty` goes high in the same cycle that the waiting character moves into the shift register. That cycle comes before the first SCLK rise of the character.
- R3: A write while `hold_empty` is low is ignored. No character is sent for it.
- R4: Take a line whose keep-active bit is 0. If the next character for the same line is in the holding register before the current character ends, the line stays low between the two characters.
- R5: When the keep-active bit of the active line is 1, the line stays low after a character even when no character is waiting.
- R6: A pulse on `last_set` raises `last_armed`. The next accepted write tags its character as final. After that character, the line is released whatever the keep-active and force-inactive bits are.
- R7: Take a line whose keep-active and force-inactive bits are both 0. If no character is waiting at the end of a character, the line is released. It then stays high for at least `cs_gap` cycles before any line asserts again.
- R8: Take a line whose force-inactive bit is 1 and keep-active bit is 0. The line goes high for at least `cs_gap` cycles between every two characters, even when the next character is already waiting.
- R9: The force-inactive bit has no effect on a line whose keep-active bit is 1.
- R10: When the waiting character targets a different line, the active line is released first. The new line (`cs_n[k]` for target number k) asserts only after at least `cs_gap` cycles. No two lines are ever low together.
- R11: `last_armed` clears itself when a write captures it. Later characters on a line held by its keep-active bit then leave the line asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | CW | Character to transmit |
| wr_cs | input | CSW | Target chip-select number |
| last_set | input | 1 | Arms the final-character flag |
| cfg_keep | input | NCS | Per-line keep-active bits |
| cfg_force_off | input | NCS | Per-line force-inactive bits |
| clk_div | input | DIVW | SCLK half-period in system cycles |
| cs_gap | input | GAPW | Minimum chip-select high time in cycles |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | NCS | Active-low chip-selects |
| hold_empty | output | 1 | Holding register can accept a write |
| last_armed | output | 1 | Final-character flag is pending |

## Verification
The hardest case to reach is the race at the end of a character. The outcome changes depending on whether the next character arrived during the shift or only after it ended. To land a reload in the middle of a character, the driver writes as soon as `hold_empty` rises. To create the late-reload case, it waits well past the end of the character. A second hard case is a line held low by its keep-active bit while the final-character flag is armed and then consumed. The bench arms the flag, writes one tagged character, and then checks that the next character on the same line no longer releases it.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2
  } csh_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] half,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] limit;

  assign limit = (half == '0) ? '0 : half - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_data,
  input  logic          shift,
  output logic          mosi
);
  logic [CW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= ld_data;
    else if (shift) sr <= {sr[CW-2:0], 1'b0};
  end

  assign mosi = sr[CW-1];
endmodule

// File: rtl/spi_hold_reg.sv
module spi_hold_reg #(
  parameter int CW  = 8,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_data,
  input  logic [CSW-1:0] wr_cs,
  input  logic           last_set,
  input  logic           take,
  output logic           full,
  output logic [CW-1:0]  data,
  output logic [CSW-1:0] cs,
  output logic           last,
  output logic           armed
);
  logic accept;
  assign accept = wr_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      data  <= '0;
      cs    <= '0;
      last  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (take) full <= 1'b0;
      if (accept) begin
        data  <= wr_data;
        cs    <= wr_cs;
        last  <= armed || last_set;
        full  <= 1'b1;
        armed <= 1'b0;
      end else if (last_set) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cs_hold_master.sv
module spi_cs_hold_master
  import spi_csh_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int CW   = 8,
  parameter int DIVW = 8,
  parameter int GAPW = 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_data,
  input  logic [CSW-1:0]  wr_cs,
  input  logic            last_set,
  input  logic [NCS-1:0]  cfg_keep,
  input  logic [NCS-1:0]  cfg_force_off,
  input  logic [DIVW-1:0] clk_div,
  input  logic [GAPW-1:0] cs_gap,
  output logic            sclk,
  output logic            mosi,
  output logic [NCS-1:0]  cs_n,
  output logic            hold_empty,
  output logic            last_armed
);
  localparam int BW = (CW > 1) ? $clog2(CW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(CW - 1);

  csh_state_t     st;
  logic           cs_on;
  logic [CSW-1:0] cur_cs;
  logic           cur_last;
  logic [BW-1:0]  bitcnt;
  logic [GAPW-1:0] gap_cnt;

  logic           h_full, h_last;
  logic [CW-1:0]  h_data;
  logic [CSW-1:0] h_cs;
  logic           tick, take, shift_en, stay, gap_done, swap;

  spi_hold_reg #(.CW(CW), .CSW(CSW)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_cs(wr_cs),
    .last_set(last_set), .take(take), .full(h_full), .data(h_data),
    .cs(h_cs), .last(h_last), .armed(last_armed)
  );

  spi_half_tick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst(rst), .en(st == ST_SHIFT), .half(clk_div), .tick(tick)
  );

  spi_tx_shift #(.CW(CW)) u_shift (
    .clk(clk), .rst(rst), .load(take), .ld_data(h_data),
    .shift(shift_en), .mosi(mosi)
  );

  assign swap     = cs_on && (h_cs != cur_cs);
  assign take     = (st == ST_IDLE) && h_full && !swap;
  assign shift_en = (st == ST_SHIFT) && tick && sclk && (bitcnt != LAST_BIT);
  assign stay     = !cur_last &&
                    (cfg_keep[cur_cs] ||
                     (!cfg_force_off[cur_cs] && h_full && (h_cs == cur_cs)));
  assign gap_done = ({1'b0, gap_cnt} + 1'b1) >= {1'b0, cs_gap};
  assign hold_empty = !h_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_n     <= '1;
      cs_on    <= 1'b0;
      cur_cs   <= '0;
      cur_last <= 1'b0;
      sclk     <= 1'b0;
      bitcnt   <= '0;
      gap_cnt  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (h_full) begin
            if (swap) begin
              cs_n    <= '1;
              cs_on   <= 1'b0;
              gap_cnt <= '0;
              st      <= ST_GAP;
            end else begin
              cs_n       <= '1;
              cs_n[h_cs] <= 1'b0;
              cs_on      <= 1'b1;
              cur_cs     <= h_cs;
              cur_last   <= h_last;
              bitcnt     <= '0;
              sclk       <= 1'b0;
              st         <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitcnt == LAST_BIT) begin
                if (stay) begin
                  st <= ST_IDLE;
                end else begin
                  cs_n    <= '1;
                  cs_on   <= 1'b0;
                  gap_cnt <= '0;
                  st      <= ST_GAP;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_done) st <= ST_IDLE;
          else          gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_hold_chk.sv
module spi_cs_hold_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           hold_empty,
  input logic           last_armed,
  input logic           sclk,
  input logic [NCS-1:0] cs_n
);
  // R10
  single_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R10
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));

  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sclk);

  // R3
  write_fills_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_empty) |=> !hold_empty);

  // R2
  empty_on_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && $past(&cs_n)) |-> hold_empty);

  // R11
  armed_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_empty && last_armed) |=> !last_armed);
endmodule

bind spi_cs_hold_master spi_cs_hold_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .hold_empty(hold_empty),
  .last_armed(last_armed), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/tb_spi_cs_hold_master.sv
module tb_spi_cs_hold_master;
  localparam int NCS = 4;
  localparam int CW  = 8;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic [CSW-1:0] wr_cs = '0;
  logic last_set = 1'b0;
  logic [NCS-1:0] cfg_keep = '0;
  logic [NCS-1:0] cfg_force_off = '0;
  logic [7:0] clk_div = 8'd2;
  logic [7:0] cs_gap = 8'd5;
  logic sclk, mosi, hold_empty, last_armed;
  logic [NCS-1:0] cs_n;

  always #5 clk = ~clk;

  spi_cs_hold_master #(.NCS(NCS), .CW(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_cs(wr_cs),
    .last_set(last_set), .cfg_keep(cfg_keep), .cfg_force_off(cfg_force_off),
    .clk_div(clk_div), .cs_gap(cs_gap), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .hold_empty(hold_empty), .last_armed(last_armed)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] exp_q[$];
  int fall_cnt[NCS];
  int last_rise = 0;
  bit seen_rise = 0;
  logic p_sclk = 1'b0;
  logic [NCS-1:0] p_csn = '1;
  logic [CW-1:0] shv = '0;
  int nbits = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < NCS; i++) fall_cnt[i] = 0;

  // monitor: rebuild characters from the pins and compare with the queue
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(~cs_n) > 1) chk(0, "R10 two lines low", $countones(~cs_n), 1);
      for (int i = 0; i < NCS; i++) begin
        if (p_csn[i] && !cs_n[i]) begin
          fall_cnt[i]++;
          if (seen_rise) chk((cyc - last_rise) >= int'(cs_gap), "R7/R8/R10 gap",
                             cyc - last_rise, int'(cs_gap));
        end
        if (!p_csn[i] && cs_n[i]) begin
          last_rise = cyc;
          seen_rise = 1;
        end
      end
      if (sclk && !p_sclk) begin
        shv = {shv[CW-2:0], mosi};
        nbits++;
        if (nbits == CW) begin
          int act_cs;
          logic [15:0] item;
          nbits = 0;
          act_cs = 0;
          for (int i = 0; i < NCS; i++) if (!cs_n[i]) act_cs = i;
          if (exp_q.size() == 0) chk(0, "R3 unexpected char", int'(shv), -1);
          else begin
            item = exp_q.pop_front();
            chk(item == {8'(act_cs), shv}, "R1 char cs/data", int'({8'(act_cs), shv}),
                int'(item));
          end
        end
      end
      p_sclk = sclk;
      p_csn  = cs_n;
    end
  end

  task automatic send(int cs, logic [7:0] d);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    wr_en = 1'b1; wr_cs = CSW'(cs); wr_data = d;
    exp_q.push_back({8'(cs), d});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm_last();
    @(negedge clk); last_set = 1'b1;
    @(negedge clk); last_set = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, base1;
    repeat (3) @(negedge clk);
    chk(cs_n == '1, "R1 reset cs_n", int'(cs_n), 15);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(hold_empty == 1'b1, "R2 reset hold_empty", hold_empty, 1);
    chk(last_armed == 1'b0, "R11 reset last_armed", last_armed, 0);
    rst = 1'b0;

    // R4 / R2: back-to-back on one line, nothing held
    base = fall_cnt[0];
    send(0, 8'hA5);
    while (!sclk) @(negedge clk);
    chk(hold_empty == 1'b1, "R2 empty before shift ends", hold_empty, 1);
    send(0, 8'h81);
    idle(120);
    chk(fall_cnt[0] - base == 1, "R4 one assertion for two chars", fall_cnt[0] - base, 1);
    chk(cs_n[0] == 1'b1, "R7 released when nothing waits", cs_n[0], 1);

    // R7: late reload gives a fresh assertion after the gap
    base = fall_cnt[0];
    send(0, 8'h3C);
    idle(120);
    send(0, 8'h00);
    idle(120);
    chk(fall_cnt[0] - base == 2, "R7 late reload reasserts", fall_cnt[0] - base, 2);

    // R5 / R6 / R11: keep-active with the final-character flag
    cfg_keep = 4'b0001;
    base = fall_cnt[0];
    send(0, 8'hFF);
    idle(120);
    chk(cs_n[0] == 1'b0, "R5 held with nothing waiting", cs_n[0], 0);
    send(0, 8'h5A);
    idle(120);
    arm_last();
    chk(last_armed == 1'b1, "R6 flag armed", last_armed, 1);
    send(0, 8'hC3);
    chk(last_armed == 1'b0, "R11 flag self-clears", last_armed, 0);
    idle(120);
    chk(cs_n[0] == 1'b1, "R6 released after final char", cs_n[0], 1);
    send(0, 8'h12);
    idle(120);
    chk(cs_n[0] == 1'b0, "R11 later char stays held", cs_n[0], 0);
    arm_last();
    send(0, 8'h7E);
    idle(120);
    chk(cs_n[0] == 1'b1, "R6 second release", cs_n[0], 1);
    chk(fall_cnt[0] - base == 2, "R5 assertion count", fall_cnt[0] - base, 2);

    // R8: force-inactive splits back-to-back characters
    cfg_keep = '0; cfg_force_off = 4'b0001;
    base = fall_cnt[0];
    send(0, 8'h96);
    send(0, 8'h69);
    idle(150);
    chk(fall_cnt[0] - base == 2, "R8 forced release between chars", fall_cnt[0] - base, 2);

    // R9: force-inactive ignored under keep-active
    cfg_keep = 4'b0001;
    base = fall_cnt[0];
    send(0, 8'hE1);
    arm_last();
    send(0, 8'h1E);
    idle(150);
    chk(fall_cnt[0] - base == 1, "R9 force ignored with keep", fall_cnt[0] - base, 1);
    chk(cs_n[0] == 1'b1, "R6 release under keep+force", cs_n[0], 1);

    // R10: switching target lines
    cfg_keep = '0; cfg_force_off = '0;
    base = fall_cnt[0]; base1 = fall_cnt[1];
    send(0, 8'h44);
    send(1, 8'hBB);
    idle(150);
    chk(fall_cnt[1] - base1 == 1, "R10 new line asserted once", fall_cnt[1] - base1, 1);
    chk(fall_cnt[0] - base == 1, "R10 old line asserted once", fall_cnt[0] - base, 1);
    chk(cs_n == '1, "R10 all released", int'(cs_n), 15);

    // R3: write into a full holding register is dropped
    send(2, 8'h29);
    send(2, 8'hD2);
    @(negedge clk);
    chk(hold_empty == 1'b0, "R3 holding full", hold_empty, 0);
    wr_en = 1'b1; wr_cs = 2'd2; wr_data = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    idle(200);
    chk(exp_q.size() == 0, "R3 queue drained, no extra char", exp_q.size(), 0);

    // R1: divider value 0 acts as 1
    clk_div = 8'd0;
    send(3, 8'hB4);
    idle(80);
    chk(exp_q.size() == 0, "R1 char with divider 0", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule